// File: doc/BRIEF.md
# Periodic Trace-Sampling Snapshot Engine

This block samples a single hardware thread. While it is switched on in trace mode, it runs a sampling-period counter that counts processor cycles. Each time the period runs out, the block takes a snapshot of the current program counter, two selected event counts and a cycle timestamp. It then streams the snapshot as a 32-byte record into a ring buffer in memory. It raises no interrupt and signals no exception: when the write position reaches the end of the ring, it goes back to the start without any indication.

Software sets up the block through two 64-bit configuration words, which reach the block as plain inputs. Bit numbering in both words counts from the most significant end, so "bit 0" means index 63. The base word holds the on switch, the mode and the ring base address. The trace word holds the sampling period, two event selects and the ring size. The block counts events from a per-cycle strobe vector. It writes records through a valid/ready write-request port, one 64-bit beat per transfer. If a period expires while a record is still being sent, the new sample is dropped and a saturating lost-sample count goes up.

Control is a four-state machine. OFF: idle, with counters and write offset cleared. RUN: sampling, no record pending. SEND: a record is being sent while sampling continues. DRAIN: a record is being finished after sampling was switched off. The transitions are:
- start (OFF to RUN) when the block becomes active.
- fire (RUN to SEND) on a period overflow.
- halt (RUN to OFF) when the block becomes inactive.
- resume (SEND to RUN) when the last beat is accepted while still active.
- finish-off (SEND to OFF) when the last beat is accepted and the block is no longer active.
- wind-down (SEND to DRAIN) when the block becomes inactive before the last beat is accepted.
- settle (DRAIN to OFF) when the last beat is accepted.

Top module: `trace_sampler`

## Requirements
- R1: After reset, `wr_valid_o` is 0 and `lost_o` is 0.
- R2: Sampling runs only when base-word bit 0 (index 63, on switch) and bit 1 (index 62, mode: 1 = trace, 0 = accumulation) are both 1. With either bit at 0, no write request is ever raised.
- R3: The ring base address is the base word masked to bits 8..50 (indices 55..13). The scope field (bits 4..6, indices 59..57), the reserved base bits, the reserved trace bits (indices 12..0) and the sample-select field (indices 63..62) have no effect on any record or address.
- R4: The trace word carries the period load value L in indices 61..30. The period counter is loaded with L and decrements once per active cycle. It overflows on the cycle that finds it at zero, then reloads L, so samples are L+1 cycles apart. The first sample carries timestamp L.
- R5: Each record is four 64-bit beats, in this order: PC, count A, count B, timestamp. The PC is the value present on the overflow cycle. Count A (select in indices 29..23) and count B (select in indices 22..16) each count the active cycles on which event strobe bit [select] was 1. A select of EVT_W or above counts nothing. The timestamp counts active cycles since sampling started.
- R6: Beat j of the k-th written record goes to base + ((32k + 8j) mod (4096 << n)), where n is the ring-size field at indices 15..13. The offset wraps to 0 without any signal.
- R7: While `wr_valid_o` is 1 and `wr_ready_i` is 0, the valid, address and data outputs hold their values into the next cycle.
- R8: An overflow that occurs while a record is being sent is dropped. It does not change the record in flight or the write offset, and it increments `lost_o`, which saturates at its maximum.
- R9: Clearing the on switch lets the record in flight complete and then stops all requests. The next activation restarts at ring offset 0 with the counters and the timestamp cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_base_i | input | 64 | Base word: on switch, mode, scope, ring base address |
| cfg_trace_i | input | 64 | Trace word: sample select, period load, event selects, ring size |
| evt_i | input | EVT_W | Per-cycle event strobes |
| pc_i | input | 64 | Current program counter |
| wr_valid_o | output | 1 | Write request valid |
| wr_ready_i | input | 1 | Write request accepted |
| wr_addr_o | output | 64 | Byte address of the current beat |
| wr_data_o | output | 64 | Current beat data |
| lost_o | output | LOST_W | Saturating count of dropped samples |

## Verification
The bench checks the exact timestamps of the first sample and of later ones. A counter that is off by one in its load or reload would move every timestamp and every PC by one. The bench runs past the end of a 4 KiB ring and checks that record 128 lands back on the base; a mask error would write past the ring or wrap early. It uses a period shorter than a record, so overflows arrive during a send. A design that overwrote the snapshot there would corrupt beats, and one that advanced the offset on a drop would leave holes in the ring. It also switches the block off in mid-record and turns it on again. A design that stopped at once would emit a partial record, and one that kept the offset would restart away from the base.

// File: rtl/trace_sampler_pkg.sv
`timescale 1ns/1ps
package trace_sampler_pkg;
    localparam int WORD_W       = 64;
    localparam int SEL_W        = 7;
    localparam int LOAD_W       = 32;
    localparam int SZ_W         = 3;
    localparam int MIN_RING_LOG = 12;
    localparam int REC_BEATS    = 4;
    localparam int BEAT_BYTES   = WORD_W / 8;
    localparam int REC_BYTES    = REC_BEATS * BEAT_BYTES;
    localparam int BEAT_IDX_W   = $clog2(REC_BEATS);

    // MSB-first bit b lives at index 63-b
    localparam int ON_IDX   = 63;
    localparam int MODE_IDX = 62;
    localparam logic [WORD_W-1:0] BASE_ADDR_MASK = 64'h00FF_FFFF_FFFF_E000;

    typedef enum logic [1:0] {ST_OFF, ST_RUN, ST_SEND, ST_DRAIN} trc_state_e;

    typedef struct packed {
        logic [1:0]        samp_sel;
        logic [LOAD_W-1:0] load;
        logic [SEL_W-1:0]  sel_a;
        logic [SEL_W-1:0]  sel_b;
        logic [SZ_W-1:0]   ring_sz;
        logic [12:0]       rsvd;
    } trace_ctl_t;
endpackage

// File: rtl/trace_sampler_period.sv
`timescale 1ns/1ps
module trace_sampler_period
    import trace_sampler_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [LOAD_W-1:0] load_i,
    output logic              ovf_o
);
    logic [LOAD_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || cnt_q == '0) begin
            cnt_q <= load_i;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign ovf_o = run_i && (cnt_q == '0);

    // R4: an overflow reloads the period value
    a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && cnt_q == '0) |=> (cnt_q == $past(load_i)));
endmodule

// File: rtl/trace_sampler_counters.sv
`timescale 1ns/1ps
module trace_sampler_counters
    import trace_sampler_pkg::*;
#(
    parameter int EVT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [EVT_W-1:0]  evt_i,
    input  logic [SEL_W-1:0]  sel_a_i,
    input  logic [SEL_W-1:0]  sel_b_i,
    output logic [WORD_W-1:0] cnt_a_o,
    output logic [WORD_W-1:0] cnt_b_o,
    output logic [WORD_W-1:0] stamp_o
);
    localparam int PAD_W = 1 << SEL_W;

    logic [PAD_W-1:0] evt_pad;
    logic             hit_a, hit_b;

    assign evt_pad = PAD_W'(evt_i);
    assign hit_a   = evt_pad[sel_a_i];
    assign hit_b   = evt_pad[sel_b_i];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_a_o <= '0;
            cnt_b_o <= '0;
            stamp_o <= '0;
        end else if (!run_i) begin
            cnt_a_o <= '0;
            cnt_b_o <= '0;
            stamp_o <= '0;
        end else begin
            cnt_a_o <= cnt_a_o + WORD_W'(hit_a);
            cnt_b_o <= cnt_b_o + WORD_W'(hit_b);
            stamp_o <= stamp_o + 1'b1;
        end
    end
endmodule

// File: rtl/trace_sampler_ring.sv
`timescale 1ns/1ps
module trace_sampler_ring
    import trace_sampler_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear_i,
    input  logic                  adv_i,
    input  logic [SZ_W-1:0]       ring_sz_i,
    input  logic [BEAT_IDX_W-1:0] beat_i,
    input  logic [WORD_W-1:0]     base_i,
    output logic [WORD_W-1:0]     addr_o
);
    localparam int OFF_W   = MIN_RING_LOG + (1 << SZ_W) - 1;
    localparam int BEAT_SH = $clog2(BEAT_BYTES);

    logic [OFF_W:0]   size_w;
    logic [OFF_W-1:0] mask, off_q, beat_off;

    assign size_w   = (OFF_W+1)'(1) << (MIN_RING_LOG + int'(ring_sz_i));
    assign mask     = OFF_W'(size_w - 1'b1);
    assign beat_off = OFF_W'(beat_i) << BEAT_SH;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q <= '0;
        end else if (clear_i) begin
            off_q <= '0;
        end else if (adv_i) begin
            off_q <= (off_q + OFF_W'(REC_BYTES)) & mask;
        end
    end

    assign addr_o = base_i + WORD_W'((off_q + beat_off) & mask);

    // R9: an idle engine restarts at the ring origin
    a_r9_offset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (off_q == '0));
endmodule

// File: rtl/trace_sampler.sv
`timescale 1ns/1ps
module trace_sampler
    import trace_sampler_pkg::*;
#(
    parameter int EVT_W  = 16,
    parameter int LOST_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [63:0]       cfg_base_i,
    input  logic [63:0]       cfg_trace_i,
    input  logic [EVT_W-1:0]  evt_i,
    input  logic [63:0]       pc_i,
    output logic              wr_valid_o,
    input  logic              wr_ready_i,
    output logic [63:0]       wr_addr_o,
    output logic [63:0]       wr_data_o,
    output logic [LOST_W-1:0] lost_o
);
    trc_state_e            state_q, state_d;
    trace_ctl_t            ctl;
    logic                  active, run, ovf, take, drop, accept, rec_done;
    logic [BEAT_IDX_W-1:0] beat_q;
    logic [WORD_W-1:0]     cnt_a, cnt_b, stamp;
    logic [WORD_W-1:0]     snap_q [REC_BEATS];
    logic                  cfg_unused;

    assign ctl        = trace_ctl_t'(cfg_trace_i);
    assign cfg_unused = ^{ctl.samp_sel, ctl.rsvd};
    assign active     = cfg_base_i[ON_IDX] & cfg_base_i[MODE_IDX];
    assign run        = active && (state_q == ST_RUN || state_q == ST_SEND);
    assign take       = ovf && (state_q == ST_RUN);
    assign drop       = ovf && (state_q == ST_SEND);
    assign accept     = wr_valid_o && wr_ready_i;
    assign rec_done   = accept && (beat_q == BEAT_IDX_W'(REC_BEATS - 1));

    trace_sampler_period u_period (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .load_i (ctl.load),
        .ovf_o  (ovf)
    );

    trace_sampler_counters #(.EVT_W(EVT_W)) u_counters (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run),
        .evt_i   (evt_i),
        .sel_a_i (ctl.sel_a),
        .sel_b_i (ctl.sel_b),
        .cnt_a_o (cnt_a),
        .cnt_b_o (cnt_b),
        .stamp_o (stamp)
    );

    trace_sampler_ring u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (state_q == ST_OFF),
        .adv_i     (rec_done),
        .ring_sz_i (ctl.ring_sz),
        .beat_i    (beat_q),
        .base_i    (cfg_base_i & BASE_ADDR_MASK),
        .addr_o    (wr_addr_o)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (active) state_d = ST_RUN;                     // start
            ST_RUN: begin
                if (!active)  state_d = ST_OFF;                         // halt
                else if (ovf) state_d = ST_SEND;                        // fire
            end
            ST_SEND: begin
                if (rec_done)     state_d = active ? ST_RUN : ST_OFF;   // resume / finish-off
                else if (!active) state_d = ST_DRAIN;                   // wind-down
            end
            ST_DRAIN: if (rec_done) state_d = ST_OFF;                   // settle
            default:  state_d = ST_OFF;
        endcase
    end

    // outputs
    always_comb begin
        wr_valid_o = (state_q == ST_SEND) || (state_q == ST_DRAIN);
        wr_data_o  = snap_q[beat_q];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q <= '0;
            for (int i = 0; i < REC_BEATS; i++) snap_q[i] <= '0;
        end else if (take) begin
            beat_q    <= '0;
            snap_q[0] <= pc_i;
            snap_q[1] <= cnt_a;
            snap_q[2] <= cnt_b;
            snap_q[3] <= stamp;
        end else if (accept) begin
            beat_q <= beat_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       lost_o <= '0;
        else if (drop && lost_o != '1)    lost_o <= lost_o + 1'b1;
    end

    // R7: a stalled beat is held unchanged
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && !wr_ready_i) |=>
            (wr_valid_o && $stable(wr_data_o) && $stable(wr_addr_o)));

    // R8: a started record is never abandoned
    a_r8_intact: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && !rec_done) |=> wr_valid_o);

    // R8: the lost-sample count sticks at its maximum
    a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (lost_o == '1) |=> (lost_o == '1));

    // R5: the first beat of a record is the PC seen at the overflow
    a_r5_pc_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_valid_o) |-> (wr_data_o == $past(pc_i)));
endmodule

// File: tb/trace_sampler_bench.sv
`timescale 1ns/1ps
module trace_sampler_bench;
    localparam logic [63:0] PC0 = 64'h4000_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] cfg_base = '0, cfg_trace = '0;
    logic [15:0] evt = 16'h0005;
    logic [63:0] pc;
    logic        ready = 1'b1;
    logic        wr_valid;
    logic [63:0] wr_addr, wr_data;
    logic [3:0]  lost;
    logic [63:0] cyc = '0;
    logic [63:0] t0 = '0;

    int errors = 0, checks = 0, nb = 0;
    logic [63:0] addr_log [1024];
    logic [63:0] data_log [1024];
    logic        prev_stall = 1'b0;
    logic [63:0] prev_addr, prev_data;

    assign pc = PC0 + cyc;

    trace_sampler #(.EVT_W(16), .LOST_W(4)) u_trace_sampler (
        .clk(clk), .rst_n(rst_n), .cfg_base_i(cfg_base), .cfg_trace_i(cfg_trace),
        .evt_i(evt), .pc_i(pc), .wr_valid_o(wr_valid), .wr_ready_i(ready),
        .wr_addr_o(wr_addr), .wr_data_o(wr_data), .lost_o(lost)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // beat monitor, sampled well after the negative edge
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            if (prev_stall) begin
                chk("R7 valid held", {63'd0, wr_valid}, 64'd1);
                chk("R7 addr held", wr_addr, prev_addr);
                chk("R7 data held", wr_data, prev_data);
            end
            prev_stall = wr_valid && !ready;
            prev_addr  = wr_addr;
            prev_data  = wr_data;
            if (wr_valid && ready) begin
                if (nb < 1024) begin
                    addr_log[nb] = wr_addr;
                    data_log[nb] = wr_data;
                end
                nb++;
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 64'd100000) begin
            errors++; checks++;
            $display("FAIL watchdog all requirements actual=%0d expected<100000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic start(input bit on, input bit mode, input logic [63:0] base,
                         input logic [1:0] ss, input logic [31:0] ld,
                         input logic [6:0] sa, input logic [6:0] sb, input logic [2:0] sz);
        @(negedge clk);
        cfg_trace = {ss, ld, sa, sb, sz, 13'd0};
        cfg_base = base;
        cfg_base[63] = on;
        cfg_base[62] = mode;
        t0 = cyc;
    endtask

    task automatic stop_and_idle(input int n);
        cfg_base[63] = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic check_rec(input string req, input int li, input int rn, input logic [63:0] ts,
                             input logic [63:0] base, input int size, input bit ha, input bit hb);
        logic [63:0] exp_d [4];
        exp_d[0] = PC0 + t0 + ts + 1;
        exp_d[1] = ha ? ts : 64'd0;
        exp_d[2] = hb ? ts : 64'd0;
        exp_d[3] = ts;
        for (int j = 0; j < 4; j++) begin
            chk(req, addr_log[li*4+j], base + 64'((rn*32 + j*8) % size));
            chk(req, data_log[li*4+j], exp_d[j]);
        end
    endtask

    task automatic t_reset();
        chk("R1 valid after reset", {63'd0, wr_valid}, 64'd0);
        chk("R1 lost after reset", {60'd0, lost}, 64'd0);
    endtask

    task automatic t_inactive();
        nb = 0;
        start(1'b1, 1'b0, 64'h0000_0000_0020_0000, 2'd0, 32'd2, 7'd0, 7'd1, 3'd0);
        repeat (30) @(negedge clk);
        chk("R2 accumulation mode silent", 64'(nb), 64'd0);
        start(1'b0, 1'b1, 64'h0000_0000_0020_0000, 2'd0, 32'd2, 7'd0, 7'd1, 3'd0);
        repeat (30) @(negedge clk);
        chk("R2 switched off silent", 64'(nb), 64'd0);
        chk("R2 valid low", {63'd0, wr_valid}, 64'd0);
    endtask

    task automatic t_basic();
        logic [63:0] b = 64'h0000_1234_5678_0000;
        nb = 0;
        start(1'b1, 1'b1, b, 2'd0, 32'd5, 7'd0, 7'd1, 3'd1);
        wait (nb >= 16);
        stop_and_idle(20);
        chk("R9 no extra record", 64'(nb), 64'd16);
        for (int i = 0; i < 4; i++)
            check_rec("R4 R5 R6 basic", i, i, 64'(5 + 6*i), b, 8192, 1'b1, 1'b0);
    endtask

    task automatic t_fields();
        logic [63:0] b = 64'h0000_0000_8000_2000;
        nb = 0;
        start(1'b1, 1'b1, b | 64'h3F00_0000_0000_1FFF, 2'd3, 32'd7, 7'd2, 7'd100, 3'd2);
        cfg_trace[12:0] = 13'h1FFF;
        wait (nb >= 12);
        stop_and_idle(20);
        for (int i = 0; i < 3; i++)
            check_rec("R3 R5 ignored fields", i, i, 64'(7 + 8*i), b, 16384, 1'b1, 1'b0);
    endtask

    task automatic t_stall();
        logic [63:0] b = 64'h0000_0000_0040_0000;
        nb = 0;
        start(1'b1, 1'b1, b, 2'd0, 32'd40, 7'd0, 7'd2, 3'd0);
        while (nb < 12) begin
            @(negedge clk);
            ready = (cyc % 3) != 0;
        end
        ready = 1'b1;
        stop_and_idle(20);
        for (int i = 0; i < 3; i++)
            check_rec("R7 stalled records", i, i, 64'(40 + 41*i), b, 4096, 1'b1, 1'b1);
    endtask

    task automatic t_wrap();
        logic [63:0] b = 64'h0000_0000_0010_0000;
        nb = 0;
        start(1'b1, 1'b1, b, 2'd0, 32'd4, 7'd0, 7'd1, 3'd0);
        wait (nb >= 520);
        stop_and_idle(20);
        chk("R6 record count", 64'(nb), 64'd520);
        for (int i = 126; i < 130; i++)
            check_rec("R6 wrap", i, i, 64'(4 + 5*i), b, 4096, 1'b1, 1'b0);
        chk("R6 record 128 at base", addr_log[512], b);
    endtask

    task automatic t_disable();
        logic [63:0] b = 64'h0000_0000_0060_0000;
        nb = 0;
        start(1'b1, 1'b1, b, 2'd0, 32'd5, 7'd0, 7'd1, 3'd2);
        wait (nb >= 9);
        stop_and_idle(30);
        chk("R9 in-flight record completes", 64'(nb), 64'd12);
        check_rec("R9 last record", 2, 2, 64'd17, b, 16384, 1'b1, 1'b0);
        nb = 0;
        start(1'b1, 1'b1, b, 2'd0, 32'd5, 7'd0, 7'd1, 3'd2);
        wait (nb >= 4);
        stop_and_idle(20);
        check_rec("R9 restart at origin", 0, 0, 64'd5, b, 16384, 1'b1, 1'b0);
    endtask

    task automatic t_drop();
        logic [63:0] b = 64'h0000_0000_0080_0000;
        logic [3:0]  l0 = lost;
        nb = 0;
        start(1'b1, 1'b1, b, 2'd0, 32'd3, 7'd0, 7'd1, 3'd0);
        wait (nb >= 12);
        @(negedge clk);
        chk("R8 drops counted", 64'(lost - l0), 64'd3);
        stop_and_idle(20);
        for (int i = 0; i < 3; i++)
            check_rec("R8 drops leave no gap", i, i, 64'(3 + 8*i), b, 4096, 1'b1, 1'b0);
    endtask

    task automatic t_saturate();
        logic [63:0] b = 64'h0000_0000_00A0_0000;
        nb = 0;
        ready = 1'b0;
        start(1'b1, 1'b1, b, 2'd0, 32'd0, 7'd0, 7'd1, 3'd0);
        repeat (40) @(negedge clk);
        chk("R8 lost saturates", {60'd0, lost}, 64'd15);
        chk("R8 record still pending", {63'd0, wr_valid}, 64'd1);
        chk("R8 nothing accepted while stalled", 64'(nb), 64'd0);
        ready = 1'b1;
        stop_and_idle(20);
        chk("R9 pending record drains", 64'(nb), 64'd4);
        check_rec("R8 first record intact", 0, 0, 64'd0, b, 4096, 1'b1, 1'b0);
        chk("R8 lost stays saturated", {60'd0, lost}, 64'd15);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_inactive();
        t_basic();
        t_fields();
        t_stall();
        t_wrap();
        t_disable();
        t_drop();
        t_saturate();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule